// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus that behaves like a small byte-addressed EEPROM of 512 locations. It oversamples the clock and data lines with a fast system clock. It finds start and stop conditions, decodes the bus traffic, and pulls the data line low through an open-drain enable whenever it acknowledges or sends a zero bit.

A master writes by sending a device byte with the direction bit at zero, then a word address, then one or more data bytes. The data bytes are collected in a page buffer. The stop that follows them launches an internal write cycle of a fixed number of system clocks. At the end of that cycle the buffered bytes are written into the storage array. While the cycle runs the slave ignores the bus entirely. A master therefore learns that the write has finished by repeating a device byte until it is acknowledged.

Reads come in three forms. A current-address read returns the byte at the internal pointer. A random read is a repeated start after a word address. A sequential read continues for as long as the master acknowledges each byte.

Top module: `tw_eeprom`

## Requirements
- R1: After reset the slave releases the data line (`sda_oe_o` = 0). A location that has never been written reads as 8'hFF.
- R2: The device byte is acknowledged only when bits 7:4 equal `DEV_CODE` (default 4'b1010). Bits 3:2 are don't-care, bit 1 carries address bit 8, and bit 0 selects the direction (1 = read). On a mismatch the slave gives no acknowledge and ignores the bus until the next start.
- R3: In a write transfer the word address byte is acknowledged, and the pointer is set to {device byte bit 1, word address}.
- R4: Each write data byte is acknowledged and stored at the pointer. After each byte only pointer bits 3:0 advance, wrapping inside the 16-byte page while bits 8:4 stay fixed. A 17th or later byte therefore overwrites earlier bytes of the same page.
- R5: Write data is held back until a stop. A stop after at least one data byte starts an internal write cycle of exactly `WRITE_CYCLES` clocks, and the bytes are written into the array at its end. A stop after only a word address starts no cycle.
- R6: While the internal write cycle runs, all bus activity is ignored, and a device byte receives no acknowledge.
- R7: Read data is sent most significant bit first, starting at the pointer. The full 9-bit pointer advances after each byte and wraps from 9'h1FF to 9'h000.
- R8: In the ninth clock of a read byte, a low data line from the master requests the next byte. A high data line (or a stop) ends the read, and the slave leaves the line released until the next start.
- R9: A current-address read begins at the address after the last byte accessed. For a read device byte, bit 1 is ignored.
- R10: A repeated start after a word address, followed by a read device byte, performs a random read from that word address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull the data line low |

## Verification
The bench builds the block with `WRITE_CYCLES` = 600 and a bus quarter-period of 8 system clocks. With these values the internal write cycle outlasts one full device byte. A poll issued straight after a stop therefore lands inside the cycle and must go unacknowledged, while a later poll succeeds. The defaults for `ADDR_W` and `PAGE_W` are kept, so page wrap, the page boundary during a sequential read, and the wrap of the top address can all be reached with a few short transfers.

// File: rtl/tw_eeprom_pkg.sv
// Package: shared types of the two-wire EEPROM slave.
// Assumes: consumers import it before declaring state registers.
package tw_eeprom_pkg;

    // Protocol phases of the slave controller
    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WADDR,
        S_WADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK
    } state_t;

endpackage

// File: rtl/tw_line_sync.sv
// Module: tw_line_sync
// Brings the bus clock and data lines into the system clock domain through
// two flops, keeps one extra delayed copy, and derives clock edges plus
// start and stop conditions from it.
// Assumes: the system clock is several times faster than the bus clock.
module tw_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_m, scl_s, scl_d;
    logic sda_m, sda_d;

    // Synchronizer and delay chain, idle-high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            scl_s <= 1'b1;
            scl_d <= 1'b1;
            sda_m <= 1'b1;
            sda_s <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_m <= scl_i;
            scl_s <= scl_m;
            scl_d <= scl_s;
            sda_m <= sda_i;
            sda_s <= sda_m;
            sda_d <= sda_s;
        end
    end

    // Edge and condition decode on the synchronized copies
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/tw_page_buf.sv
// Module: tw_page_buf
// Collects the write bytes of one page with a per-byte valid mask and runs
// the internal write timer. The commit strobe is raised in the last busy
// cycle, and the buffered bytes are then written to the array.
// Assumes: launch is only raised by the controller on a stop after write data.
module tw_page_buf #(
    parameter int DATA_W       = 8,
    parameter int PAGE_W       = 4,
    parameter int PAGE_IDX_W   = 5,
    parameter int WRITE_CYCLES = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           wr_en,
    input  logic [PAGE_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           launch,
    input  logic [PAGE_IDX_W-1:0]          launch_page,
    output logic                           busy,
    output logic                           commit,
    output logic [PAGE_IDX_W-1:0]          commit_page,
    output logic [(DATA_W<<PAGE_W)-1:0]    commit_data,
    output logic [(1<<PAGE_W)-1:0]         commit_mask
);

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

    logic [DATA_W-1:0]     buf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;
    logic [CNT_W-1:0]      cnt_q;

    // Commit happens on the final cycle of the write timer
    assign commit = busy && (cnt_q == '0);

    // Byte storage and valid mask of the open page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= '0;
        end else if (commit || clr) begin
            mask_q <= '0;
        end else if (wr_en && !busy) begin
            buf_q[wr_idx]  <= wr_data;
            mask_q[wr_idx] <= 1'b1;
        end
    end

    // Internal write timer, started by a stop with data pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            cnt_q       <= '0;
            commit_page <= '0;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end else if (launch && (mask_q != '0)) begin
            busy        <= 1'b1;
            cnt_q       <= CNT_W'(WRITE_CYCLES - 1);
            commit_page <= launch_page;
        end
    end

    // Flatten buffer lanes for the storage array
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        assign commit_data[g*DATA_W +: DATA_W] = buf_q[g];
    end
    assign commit_mask = mask_q;

endmodule

// File: rtl/tw_store.sv
// Module: tw_store
// Plain register array holding the EEPROM contents. One combinational read
// port; a page-wide write port that updates every masked lane of one page.
// Assumes: contents are set to the erased value by reset (no retention).
module tw_store #(
    parameter int              ADDR_W = 9,
    parameter int              DATA_W = 8,
    parameter int              PAGE_W = 4,
    parameter logic [DATA_W-1:0] ERASED = 8'hFF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    input  logic                           commit,
    input  logic [ADDR_W-PAGE_W-1:0]       commit_page,
    input  logic [(DATA_W<<PAGE_W)-1:0]    commit_data,
    input  logic [(1<<PAGE_W)-1:0]         commit_mask
);

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    // Erase on reset, page-wide masked update on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a[ADDR_W-1:0]] <= ERASED;
        end else if (commit) begin
            for (int l = 0; l < PAGE_BYTES; l++) begin
                if (commit_mask[l])
                    mem[{commit_page, l[PAGE_W-1:0]}] <= commit_data[l*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/tw_eeprom.sv
// Module: tw_eeprom (top)
// Two-wire EEPROM slave: decodes device, address and data bytes, acknowledges,
// shifts read data out, and hands write bytes to the page buffer, whose
// internal write cycle makes the slave deaf until it completes.
// Assumes: ADDR_W is 9..11 (upper address bits ride in the device byte).
module tw_eeprom #(
    parameter int         ADDR_W       = 9,
    parameter int         PAGE_W       = 4,
    parameter int         WRITE_CYCLES = 64,
    parameter logic [3:0] DEV_CODE     = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    import tw_eeprom_pkg::*;

    localparam int HI_W       = ADDR_W - 8;
    localparam int PAGE_IDX_W = ADDR_W - PAGE_W;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, commit;
    logic [PAGE_IDX_W-1:0]   commit_page;
    logic [(8<<PAGE_W)-1:0]  commit_data;
    logic [(1<<PAGE_W)-1:0]  commit_mask;
    logic [7:0]              rd_data;

    state_t             state_q;
    logic [3:0]         bitcnt_q;
    logic [7:0]         shreg_q;
    logic [7:0]         tx_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic [HI_W-1:0]    hi_q;
    logic               rd_is_q;
    logic               mst_ack_q;
    logic               oe_q;

    logic byte_done, buf_wr, buf_clr, launch, rd_load;

    tw_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    // Strobes toward the page buffer and the read port
    always_comb begin
        byte_done = scl_fall && (bitcnt_q == 4'd8);
        buf_wr    = (state_q == S_WDATA) && byte_done && !start_det && !stop_det;
        buf_clr   = !busy && (start_det ||
                    ((state_q == S_WADDR) && byte_done && !stop_det));
        launch    = stop_det && !busy &&
                    ((state_q == S_WDATA) || (state_q == S_WDATA_ACK));
        rd_load   = !busy && !start_det && !stop_det && scl_fall &&
                    (((state_q == S_DEV_ACK) && rd_is_q) ||
                     ((state_q == S_RACK) && mst_ack_q));
    end

    tw_page_buf #(
        .DATA_W(8), .PAGE_W(PAGE_W), .PAGE_IDX_W(PAGE_IDX_W),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
        .wr_idx(ptr_q[PAGE_W-1:0]), .wr_data(shreg_q),
        .launch(launch), .launch_page(ptr_q[ADDR_W-1:PAGE_W]),
        .busy(busy), .commit(commit), .commit_page(commit_page),
        .commit_data(commit_data), .commit_mask(commit_mask)
    );

    tw_store #(.ADDR_W(ADDR_W), .DATA_W(8), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(ptr_q), .rd_data(rd_data),
        .commit(commit), .commit_page(commit_page),
        .commit_data(commit_data), .commit_mask(commit_mask)
    );

    // Protocol controller: bit counting, acknowledge and read data drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            bitcnt_q  <= '0;
            shreg_q   <= '0;
            tx_q      <= '0;
            ptr_q     <= '0;
            hi_q      <= '0;
            rd_is_q   <= 1'b0;
            mst_ack_q <= 1'b0;
            oe_q      <= 1'b0;
        end else if (busy) begin
            state_q <= S_IDLE;
            oe_q    <= 1'b0;
        end else if (start_det) begin
            state_q  <= S_DEV;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
        end else if (stop_det) begin
            state_q <= S_IDLE;
            oe_q    <= 1'b0;
        end else begin
            unique case (state_q)
                S_DEV, S_WADDR, S_WDATA: begin
                    if (scl_rise && bitcnt_q != 4'd8) begin
                        shreg_q  <= {shreg_q[6:0], sda_s};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    if (byte_done) begin
                        bitcnt_q <= '0;
                        if (state_q == S_DEV) begin
                            if (shreg_q[7:4] == DEV_CODE) begin
                                oe_q    <= 1'b1;
                                rd_is_q <= shreg_q[0];
                                state_q <= S_DEV_ACK;
                                if (!shreg_q[0]) hi_q <= shreg_q[HI_W:1];
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end else if (state_q == S_WADDR) begin
                            ptr_q   <= {hi_q, shreg_q};
                            oe_q    <= 1'b1;
                            state_q <= S_WADDR_ACK;
                        end else begin
                            ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
                            oe_q    <= 1'b1;
                            state_q <= S_WDATA_ACK;
                        end
                    end
                end
                S_DEV_ACK: begin
                    if (scl_fall) begin
                        if (rd_is_q) begin
                            tx_q     <= rd_data;
                            oe_q     <= ~rd_data[7];
                            ptr_q    <= ptr_q + 1'b1;
                            bitcnt_q <= '0;
                            state_q  <= S_RDATA;
                        end else begin
                            oe_q    <= 1'b0;
                            state_q <= S_WADDR;
                        end
                    end
                end
                S_WADDR_ACK, S_WDATA_ACK: begin
                    if (scl_fall) begin
                        oe_q    <= 1'b0;
                        state_q <= S_WDATA;
                    end
                end
                S_RDATA: begin
                    if (scl_rise) bitcnt_q <= bitcnt_q + 1'b1;
                    if (scl_fall) begin
                        if (bitcnt_q == 4'd8) begin
                            oe_q    <= 1'b0;
                            state_q <= S_RACK;
                        end else begin
                            tx_q <= {tx_q[6:0], 1'b0};
                            oe_q <= ~tx_q[6];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) mst_ack_q <= ~sda_s;
                    if (scl_fall) begin
                        if (mst_ack_q) begin
                            tx_q     <= rd_data;
                            oe_q     <= ~rd_data[7];
                            ptr_q    <= ptr_q + 1'b1;
                            bitcnt_q <= '0;
                            state_q  <= S_RDATA;
                        end else begin
                            state_q <= S_IDLE;
                        end
                    end
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign sda_oe_o = oe_q;

endmodule

// File: rtl/tw_eeprom_checker.sv
// Module: tw_eeprom_checker
// Temporal checks on the slave, bound into every tw_eeprom instance.
// Assumes: WRITE_CYCLES >= 1.
module tw_eeprom_checker #(
    parameter int ADDR_W       = 9,
    parameter int PAGE_W       = 4,
    parameter int WRITE_CYCLES = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sda_oe,
    input logic                  busy,
    input logic                  commit,
    input logic                  buf_wr,
    input logic                  rd_load,
    input logic [ADDR_W-1:0]     ptr,
    input tw_eeprom_pkg::state_t state
);
    localparam int BC_W = $clog2(WRITE_CYCLES + 2);

    logic [BC_W-1:0] busy_cnt;

    // Length of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    a_r6_deaf_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    a_r5_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == BC_W'(WRITE_CYCLES)));

    a_r5_commit_ends_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);

    a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

    a_r7_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == tw_eeprom_pkg::S_IDLE) |-> !sda_oe);

endmodule

bind tw_eeprom tw_eeprom_checker #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .busy(busy),
    .commit(commit), .buf_wr(buf_wr), .rd_load(rd_load),
    .ptr(ptr_q), .state(state_q)
);

// File: tb/tw_eeprom_bench.sv
// Directed bench for tw_eeprom: a bit-level bus master plus a memory model.
module tw_eeprom_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WC         = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic done = 1'b0;

    int total = 0;
    int bad   = 0;

    logic [7:0] model [512];
    logic [7:0] wbuf  [32];
    logic [7:0] rbuf  [32];

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_eeprom #(.WRITE_CYCLES(WC)) u_tw_eeprom (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(Q);
            scl_m = 1'b1; hold(2*Q);
            scl_m = 1'b0; hold(Q);
        end
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        acked = (sda_line == 1'b0);
        hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(Q);
            scl_m = 1'b1; hold(Q);
            d[i] = sda_line;
            hold(Q);
            scl_m = 1'b0;
        end
        hold(Q);
        sda_m = ~give_ack; hold(Q);
        scl_m = 1'b1; hold(2*Q);
        scl_m = 1'b0; hold(Q);
    endtask

    // Write n bytes of wbuf from address a, and update the model page-wise
    task automatic write_seq(input logic [8:0] a, input int n);
        logic ack;
        logic [8:0] idx;
        bus_start();
        send_byte({4'b1010, 2'b00, a[8], 1'b0}, ack);
        check("R2 device ack", 32'(ack), 1);
        send_byte(a[7:0], ack);
        check("R3 word address ack", 32'(ack), 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            check("R4 data ack", 32'(ack), 1);
            idx = {a[8:4], a[3:0] + 4'(i)};
            model[idx] = wbuf[i];
        end
        bus_stop();
    endtask

    // Acknowledge polling until the slave answers
    task automatic wait_ready();
        logic ack;
        int tries = 0;
        ack = 1'b0;
        while (!ack && tries < 20) begin
            bus_start();
            send_byte(8'hA0, ack);
            bus_stop();
            tries++;
        end
        check("R5 write cycle ends", 32'(ack), 1);
    endtask

    task automatic read_random(input logic [8:0] a, input int n);
        logic ack;
        bus_start();
        send_byte({4'b1010, 2'b00, a[8], 1'b0}, ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(8'hA1, ack);
        check("R10 read device ack", 32'(ack), 1);
        for (int i = 0; i < n; i++) recv_byte(i != n-1, rbuf[i]);
        bus_stop();
    endtask

    task automatic read_current(input logic [7:0] dev, input int n);
        logic ack;
        bus_start();
        send_byte(dev, ack);
        check("R9 current read ack", 32'(ack), 1);
        for (int i = 0; i < n; i++) recv_byte(i != n-1, rbuf[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R1 line released after reset", 32'(sda_oe), 0);
    endtask

    task automatic t_bad_device();
        logic ack;
        bus_start();
        send_byte(8'h60, ack);
        check("R2 mismatch gets no ack", 32'(ack), 0);
        send_byte(8'h00, ack);
        check("R2 ignored after mismatch", 32'(ack), 0);
        bus_stop();
    endtask

    task automatic t_byte_write_poll();
        logic ack;
        wbuf[0] = 8'h5A;
        write_seq(9'h123, 1);
        bus_start();
        send_byte(8'hA0, ack);
        check("R6 no ack during write cycle", 32'(ack), 0);
        bus_stop();
        wait_ready();
        read_random(9'h123, 1);
        check("R10 random read of written byte", 32'(rbuf[0]), 32'(model[9'h123]));
    endtask

    task automatic t_addr_only();
        logic ack;
        write_seq(9'h010, 0);
        bus_start();
        send_byte(8'hA0, ack);
        check("R5 no cycle without data", 32'(ack), 1);
        bus_stop();
        read_current(8'hA1, 1);
        check("R1 erased value", 32'(rbuf[0]), 32'hFF);
    endtask

    task automatic t_page_wrap();
        for (int i = 0; i < 18; i++) wbuf[i] = 8'h30 + 8'(i);
        write_seq(9'h04C, 18);
        wait_ready();
        read_random(9'h040, 17);
        for (int i = 0; i < 17; i++)
            check("R4 page wrap contents", 32'(rbuf[i]), 32'(model[9'h040 + 9'(i)]));
    endtask

    task automatic t_current_nack();
        logic [7:0] d;
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        write_seq(9'h0A0, 2);
        wait_ready();
        write_seq(9'h0A0, 0);
        bus_start();
        send_byte(8'hA3, d[0]);
        recv_byte(1'b0, d);
        check("R9 bit 1 ignored on read", 32'(d), 32'h77);
        check("R8 released after nack", 32'(sda_oe), 0);
        hold(4*Q);
        check("R8 stays released", 32'(sda_oe), 0);
        bus_stop();
        read_current(8'hA1, 1);
        check("R9 next address after read", 32'(rbuf[0]), 32'h88);
    endtask

    task automatic t_top_wrap();
        wbuf[0] = 8'hE1;
        write_seq(9'h1FF, 1);
        wait_ready();
        wbuf[0] = 8'h0E;
        write_seq(9'h000, 1);
        wait_ready();
        read_random(9'h1FF, 2);
        check("R7 top byte", 32'(rbuf[0]), 32'hE1);
        check("R7 wrap to zero", 32'(rbuf[1]), 32'h0E);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) model[i] = 8'hFF;
        hold(5);
        rst_n = 1'b1;
        hold(5);
        t_reset();
        t_bad_device();
        t_byte_write_poll();
        t_addr_only();
        t_page_wrap();
        t_current_nack();
        t_top_wrap();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule